// File: doc/BRIEF.md
# Double-Buffered Stereo Sample Loader

This block sits between a host processor and the serializer of a two-channel audio transmitter. The host writes each stereo frame through one write-only data port. The first write after a frame boundary lands in the channel A holding register, the next in the channel B holding register, and writes keep alternating after that. When the framer signals a frame start, the A sample is presented at once as parallel load data for the output shift register. At the same moment the B sample moves into a hidden channel B buffer. When the framer later signals the start of channel B, the buffered sample is presented as load data. The holding registers are then free, so the host has a whole frame period to write the next pair.

An empty flag shows whether a complete pair is waiting. An interrupt pulse at each frame start asks the host for the next pair. If a frame starts before the B sample was written, the block sends the previous frame's samples again and latches a sticky underrun flag. Only the host clears that flag.

Top module: `stereo_sample_loader`

## Requirements
- R1: After synchronous reset, `emptyFlag` is 1; `underrunFlag`, `irq`, `loadStrobe` are 0; `loadData` is 0; the write pointer selects channel A.
- R2: Successive `wrEn` writes go alternately to the channel A and channel B holding registers, starting with A.
- R3: A `frameStart` pulse forces the write pointer back to A, so the next write lands in A whatever the pointer held before.
- R4: A write that lands in channel B clears `emptyFlag` in the next cycle; every `frameStart` sets it; a write to A leaves it unchanged.
- R5: In the cycle after a normal `frameStart`, `loadStrobe` is 1 and `loadData` equals the channel A holding register; in the same transfer the B holding register moves into the channel B buffer. `loadData` holds its value while no load happens, and `loadStrobe` is 0 in any cycle that follows no load request.
- R6: In the cycle after `chBStart`, `loadStrobe` is 1 and `loadData` equals the channel B buffer. Host writes made after the frame start do not alter it.
- R7: In the cycle after `frameStart`, `irq` is 1 for one cycle if `irqEnable` was 1, and `irq` stays 0 otherwise.
- R8: A `frameStart` while `emptyFlag` is 1 is an underrun. `loadData` repeats the A sample sent at the previous normal frame start, the channel B buffer keeps its content, and `underrunFlag` becomes 1 and stays 1.
- R9: `clrUnderrun` clears `underrunFlag` in the next cycle. If an underrun happens in the same cycle, the flag is set instead.
- R10: A write in the same cycle as `frameStart` is stored in channel A and moves the pointer to B. The transfer uses the A value held before that write.
- R11: When `frameStart` and `chBStart` arrive together, the frame start transfer takes place and the channel B load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Host write strobe for the shared data port |
| wrData | input | 24 | Host write data |
| frameStart | input | 1 | Pulse from the framer at each frame boundary |
| chBStart | input | 1 | Pulse from the framer when the channel B subframe begins |
| irqEnable | input | 1 | Enables the frame start interrupt pulse |
| clrUnderrun | input | 1 | Host strobe that clears the underrun flag |
| loadData | output | 24 | Parallel load value for the output shift register |
| loadStrobe | output | 1 | One-cycle pulse when loadData holds a new sample |
| emptyFlag | output | 1 | 1 while no complete sample pair is waiting |
| underrunFlag | output | 1 | Sticky flag: a frame started with no new pair |
| irq | output | 1 | One-cycle interrupt request at frame start |

## Verification
Some functions can fall in the same cycle. A host write can meet a frame start. A frame start can meet a channel B start. An underrun can meet a host clear of the underrun flag. The vector walk provokes each of these. It drives the colliding pulses on one clock edge, then judges the outcome at the ports. For the write collision it checks the loaded value, and a follow-on write proves the pointer moved on. For the framer collision it checks which sample reaches `loadData`. For the flag collision it checks the value of `underrunFlag`.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  localparam int unsigned SAMPLE_W = 24;

  typedef struct packed {
    logic wrA;        // store host data in channel A holding register
    logic wrB;        // store host data in channel B holding register
    logic xferFrame;  // frame start transfer
    logic replay;     // frame start is an underrun: resend previous samples
    logic xferB;      // load channel B buffer into shift register
  } ssl_strobe_t;
endpackage

// File: rtl/ssl_ctrl.sv
module ssl_ctrl
  import ssl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        frameStart,
  input  logic        chBStart,
  input  logic        irqEnable,
  input  logic        clrUnderrun,
  output ssl_strobe_t strobes,
  output logic        emptyFlag,
  output logic        underrunFlag,
  output logic        irq
);

  logic ptrB;       // 0: next write goes to A, 1: to B
  logic effPtrB;    // pointer after the frame start override

  always_comb begin
    effPtrB           = frameStart ? 1'b0 : ptrB;
    strobes.wrA       = wrEn & ~effPtrB;
    strobes.wrB       = wrEn & effPtrB;
    strobes.xferFrame = frameStart;
    strobes.replay    = frameStart & emptyFlag;
    strobes.xferB     = chBStart & ~frameStart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptrB         <= 1'b0;
      emptyFlag    <= 1'b1;
      underrunFlag <= 1'b0;
      irq          <= 1'b0;
    end else begin
      if (wrEn)
        ptrB <= ~effPtrB;
      else if (frameStart)
        ptrB <= 1'b0;

      if (frameStart)
        emptyFlag <= 1'b1;
      else if (strobes.wrB)
        emptyFlag <= 1'b0;

      if (frameStart && emptyFlag)
        underrunFlag <= 1'b1;
      else if (clrUnderrun)
        underrunFlag <= 1'b0;

      irq <= frameStart & irqEnable;
    end
  end

  // R3: frame start without a write leaves the pointer on A
  p_ptr_force_r3: assert property (@(posedge clk) disable iff (rst)
    (frameStart && !wrEn) |=> !ptrB);

  // R10: write colliding with frame start moves the pointer to B
  p_collide_ptr_r10: assert property (@(posedge clk) disable iff (rst)
    (frameStart && wrEn) |=> ptrB);

  // R4: frame start sets the empty flag
  p_empty_set_r4: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> emptyFlag);

  // R4: a B write outside a frame start clears the empty flag
  p_empty_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wrEn && ptrB && !frameStart) |=> !emptyFlag);

  // R7: interrupt follows an enabled frame start
  p_irq_raise_r7: assert property (@(posedge clk) disable iff (rst)
    (frameStart && irqEnable) |=> irq);

  // R7: no interrupt without an enabled frame start
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !(frameStart && irqEnable) |=> !irq);

  // R8: underrun latches
  p_underrun_set_r8: assert property (@(posedge clk) disable iff (rst)
    (frameStart && emptyFlag) |=> underrunFlag);

  // R8: underrun stays until cleared
  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (underrunFlag && !clrUnderrun) |=> underrunFlag);

  // R9: clear without a new underrun drops the flag
  p_underrun_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (clrUnderrun && !(frameStart && emptyFlag)) |=> !underrunFlag);

endmodule

// File: rtl/ssl_datapath.sv
module ssl_datapath
  import ssl_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  ssl_strobe_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadData,
  output logic              loadStrobe
);

  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] holdA;
  logic [DATA_W-1:0] holdB;
  logic [DATA_W-1:0] bufB;
  logic [DATA_W-1:0] lastA;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdA <= ZERO;
      holdB <= ZERO;
    end else begin
      if (strobes.wrA) holdA <= wrData;
      if (strobes.wrB) holdB <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufB       <= ZERO;
      lastA      <= ZERO;
      loadData   <= ZERO;
      loadStrobe <= 1'b0;
    end else begin
      loadStrobe <= strobes.xferFrame | strobes.xferB;
      if (strobes.xferFrame) begin
        if (strobes.replay) begin
          loadData <= lastA;
        end else begin
          loadData <= holdA;
          lastA    <= holdA;
          bufB     <= holdB;
        end
      end else if (strobes.xferB) begin
        loadData <= bufB;
      end
    end
  end

  // R5: a load request yields a strobe
  p_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.xferFrame || strobes.xferB) |=> loadStrobe);

  // R5: no request, no strobe, data held
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !(strobes.xferFrame || strobes.xferB) |=> (!loadStrobe && $stable(loadData)));

  // R5: normal frame start presents the A sample
  p_frame_load_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.xferFrame && !strobes.replay) |=> (loadData == $past(holdA)));

  // R6: channel B buffer only changes on a normal frame start
  p_bufb_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(strobes.xferFrame && !strobes.replay) |=> $stable(bufB));

  // R8: underrun keeps the previous A sample for resending
  p_replay_r8: assert property (@(posedge clk) disable iff (rst)
    (strobes.xferFrame && strobes.replay) |=> (loadData == $past(lastA)));

endmodule

// File: rtl/stereo_sample_loader.sv
module stereo_sample_loader
  import ssl_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameStart,
  input  logic              chBStart,
  input  logic              irqEnable,
  input  logic              clrUnderrun,
  output logic [DATA_W-1:0] loadData,
  output logic              loadStrobe,
  output logic              emptyFlag,
  output logic              underrunFlag,
  output logic              irq
);

  ssl_strobe_t strobes;

  ssl_ctrl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .wrEn         (wrEn),
    .frameStart   (frameStart),
    .chBStart     (chBStart),
    .irqEnable    (irqEnable),
    .clrUnderrun  (clrUnderrun),
    .strobes      (strobes),
    .emptyFlag    (emptyFlag),
    .underrunFlag (underrunFlag),
    .irq          (irq)
  );

  ssl_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .wrData     (wrData),
    .loadData   (loadData),
    .loadStrobe (loadStrobe)
  );

  // R11: framer collision never produces two loads in a row from one cycle
  p_frame_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (frameStart && chBStart) |=> (loadStrobe && emptyFlag));

endmodule

// File: tb/stereo_sample_loader_tb_top.sv
module stereo_sample_loader_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [23:0] wrData;
  logic        frameStart;
  logic        chBStart;
  logic        irqEnable;
  logic        clrUnderrun;
  logic [23:0] loadData;
  logic        loadStrobe;
  logic        emptyFlag;
  logic        underrunFlag;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stereo_sample_loader dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .frameStart(frameStart), .chBStart(chBStart), .irqEnable(irqEnable),
    .clrUnderrun(clrUnderrun), .loadData(loadData), .loadStrobe(loadStrobe),
    .emptyFlag(emptyFlag), .underrunFlag(underrunFlag), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [23:0] data;
    logic        fs;
    logic        cbs;
    logic        ien;
    logic        clr;
    logic        eStb;
    logic [23:0] eLoad;
    logic        eEmp;
    logic        eUnd;
    logic        eIrq;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 24;
  // fields: wr data fs cbs ien clr | stb load empty underrun irq | req
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 24'h111111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 first write to A
    '{1'b1, 24'h222222, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 B write clears empty
    '{1'b0, 24'h000000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 24'h111111, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 R7
    '{1'b1, 24'h333333, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h111111, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 lands in A
    '{1'b0, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 24'h222222, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 buffered B
    '{1'b1, 24'h444444, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h222222, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 second write to B
    '{1'b0, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 24'h333333, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 disabled irq
    '{1'b0, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 24'h444444, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 24'h000000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 24'h333333, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 underrun resend A
    '{1'b0, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 24'h444444, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 resend B
    '{1'b1, 24'h555555, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h444444, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 sticky
    '{1'b1, 24'h666666, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h444444, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 24'h777777, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h444444, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 A write keeps empty
    '{1'b1, 24'h888888, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 24'h777777, 1'b1, 1'b1, 1'b1, 4'd10}, // R10 collision
    '{1'b1, 24'h999999, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h777777, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 pointer on B
    '{1'b0, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 24'h777777, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 clear
    '{1'b0, 24'h000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 24'h888888, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 frame wins
    '{1'b0, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 24'h999999, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 buffer from frame
    '{1'b1, 24'hAAAAAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h999999, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 24'h888888, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 set wins over clear
    '{1'b1, 24'hBBBBBB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h888888, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 forced to A
    '{1'b1, 24'hCCCCCC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h888888, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 then B
    '{1'b0, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 24'hBBBBBB, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 A sample sent
    '{1'b0, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 24'hCCCCCC, 1'b1, 1'b1, 1'b0, 4'd6}   // R6
  };

  task automatic checkOut(input string tag, input logic eStb, input logic [23:0] eLoad,
                          input logic eEmp, input logic eUnd, input logic eIrq);
    checks++;
    if (loadStrobe !== eStb || loadData !== eLoad || emptyFlag !== eEmp ||
        underrunFlag !== eUnd || irq !== eIrq) begin
      fails++;
      $display("FAIL %s: actual stb=%b load=%h empty=%b under=%b irq=%b expected stb=%b load=%h empty=%b under=%b irq=%b",
               tag, loadStrobe, loadData, emptyFlag, underrunFlag, irq,
               eStb, eLoad, eEmp, eUnd, eIrq);
    end
  endtask

  task automatic idleInputs();
    wrEn = 1'b0; wrData = '0; frameStart = 1'b0; chBStart = 1'b0;
    irqEnable = 1'b0; clrUnderrun = 1'b0;
  endtask

  initial begin
    idleInputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checkOut("R1 reset state", 1'b0, 24'h0, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      wrEn        = VEC[i].wr;
      wrData      = VEC[i].data;
      frameStart  = VEC[i].fs;
      chBStart    = VEC[i].cbs;
      irqEnable   = VEC[i].ien;
      clrUnderrun = VEC[i].clr;
      @(negedge clk);
      checkOut($sformatf("R%0d vector %0d", VEC[i].req, i),
               VEC[i].eStb, VEC[i].eLoad, VEC[i].eEmp, VEC[i].eUnd, VEC[i].eIrq);
    end

    // R5: idle cycle drops the strobe and holds the data
    idleInputs();
    @(negedge clk);
    checkOut("R5 idle hold", 1'b0, 24'hCCCCCC, 1'b1, 1'b1, 1'b0);

    // R1: reset in mid-run restores the reset state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkOut("R1 mid-run reset", 1'b0, 24'h0, 1'b1, 1'b0, 1'b0);

    // R1 R8: first frame after reset underruns and sends zero
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    checkOut("R1 R8 frame after reset", 1'b1, 24'h0, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule